// File: doc/BRIEF.md
# Free-Running Compare Timer

This peripheral holds a free-running up-counter that software reads through a small synchronous register bus. The counter steps once for each tick. The tick comes from a selectable source: the bus clock itself, a peripheral clock enable, or an oscillator enable that first passes through its own divider. A general prescaler then divides whichever source is selected.

One compare channel watches the counter. On the edge where the counter steps onto the compare value, a sticky status flag is set. Software clears the flag by writing one to it. An interrupt output shows the flag whenever the matching enable bit is set. To schedule an event, software reads the counter, adds a delta and writes the sum to the compare register. Because the match is an exact equality test, a compare value at or just below the current count only fires after the counter wraps.

All register reads are combinational from registered state. Writes take effect on the clock edge where `bus_we` is high.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: The control register keeps bit 0 (run), bit 3 (wait flag), bits 8:6 (source code), bit 9 (free-run) and bit 10 (oscillator gate), and reads all other bits as 0. The prescaler register keeps bits 15:0. The wait and free-run bits have no effect on counting.
- R3: The counter only advances while control bit 0 is 1. The counter register at offset 0x24 is read-only, and writes to it are ignored.
- R4: Source code 1 ticks on every bus clock, code 2 on each `per_tick_i` pulse and code 5 on each divided oscillator pulse. Any other code gives no ticks.
- R5: Prescaler bits 11:0 hold a value N, and the selected source is divided by N+1.
- R6: The oscillator path passes pulses only while control bit 10 is 1. It divides `osc_tick_i` by the value of prescaler bits 15:12 plus 1, so a field of 7 divides by 8.
- R7: Status bit 0 is set on the edge where the counter steps onto the compare value. A compare value equal to or one below the current count fires only after the counter wraps to 0.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A match on the same edge as a clear leaves the flag set.
- R9: `irq_o` is status bit 0 AND interrupt-enable bit 0. Writing 0 to the enable masks `irq_o` but keeps the flag.
- R10: Whenever the counter changes, it moves up by exactly 1, modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| per_tick_i | input | 1 | Peripheral clock enable pulse |
| osc_tick_i | input | 1 | Oscillator enable pulse |
| irq_o | output | 1 | Compare interrupt |

## Verification
The assertions check four behaviours on every cycle:
- the counter only ever steps by one;
- the counter holds still while the run bit is clear;
- the flag only rises with the counter equal to the compare value;
- the flag only falls after a write of one to the status bit.

Only the bench scenarios can show the tick rates, because each rate is a count of steps over a measured window. This covers the prescaler and oscillator division, the effect of each source code, the wrap-around delay of a compare set below the count, and the exact cycle on which the flag and interrupt appear.

// File: rtl/tmr_pkg.sv
// Shared register offsets, control field positions and source codes.
package tmr_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_PRE  = 'h04;
    localparam int OFF_STAT = 'h08;
    localparam int OFF_IEN  = 'h0C;
    localparam int OFF_CMP  = 'h10;
    localparam int OFF_CNT  = 'h24;

    localparam int BIT_RUN  = 0;
    localparam int BIT_WAIT = 3;
    localparam int SRC_LSB  = 6;
    localparam int SRC_W    = 3;
    localparam int BIT_FREE = 9;
    localparam int BIT_OSC  = 10;

    localparam int PRE_W    = 12;
    localparam int OSCDIV_LSB = 12;
    localparam int OSCDIV_W = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_BUS = 3'd1,
        SRC_PER = 3'd2,
        SRC_OSC = 3'd5
    } src_e;

    typedef struct packed {
        logic            osc_gate;
        logic            free_run;
        logic [SRC_W-1:0] src;
        logic            wait_flag;
        logic            run;
    } ctrl_t;
endpackage

// File: rtl/tmr_div_stage.sv
// Pulse divider: passes one of every (div+1) input pulses.
// Assumes input pulses last one cycle. A divisor that shrinks below the
// running count makes the next pulse pass at once.
module tmr_div_stage #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse_in,
    input  logic [DIV_W-1:0] div,
    output logic             pulse_out
);
    logic [DIV_W-1:0] cnt_q;
    logic             hit;

    // Last pulse of a division period.
    assign hit       = (cnt_q >= div);
    assign pulse_out = pulse_in && hit;

    // Count input pulses and restart after each output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (pulse_in)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_tick_gen.sv
// Picks the tick source and applies the oscillator divider and prescaler.
// Assumes clr is high while the timer is stopped, so both dividers restart.
module tmr_tick_gen
    import tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [SRC_W-1:0]    src,
    input  logic                osc_gate,
    input  logic [OSCDIV_W-1:0] osc_div,
    input  logic [PRE_W-1:0]    pre_div,
    input  logic                per_tick_i,
    input  logic                osc_tick_i,
    output logic                tick
);
    logic osc_in, osc_pulse, src_pulse;

    // The oscillator path only sees pulses while its gate bit is set.
    assign osc_in = osc_tick_i && osc_gate;

    tmr_div_stage #(.DIV_W(OSCDIV_W)) u_oscdiv (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .pulse_in(osc_in), .div(osc_div), .pulse_out(osc_pulse)
    );

    // Source selection by code; unknown codes produce no pulse.
    always_comb begin
        unique case (src)
            SRC_BUS: src_pulse = 1'b1;
            SRC_PER: src_pulse = per_tick_i;
            SRC_OSC: src_pulse = osc_pulse;
            default: src_pulse = 1'b0;
        endcase
    end

    tmr_div_stage #(.DIV_W(PRE_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .pulse_in(src_pulse), .div(pre_div), .pulse_out(tick)
    );
endmodule

// File: rtl/tmr_counter.sv
// Up-counter with compare. match pulses on the edge where the count steps
// onto cmp. Wrap-around is the natural modulo-2^CNT_W overflow.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] nxt;

    assign nxt   = cnt + 1'b1;
    assign match = adv && (nxt == cmp);

    // Step the count on each tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= nxt;
    end
endmodule

// File: rtl/tmr_regs.sv
// Register file: control, prescaler, sticky compare flag (write-one-to-clear),
// interrupt enable, compare value and read mux. The counter is read-only.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              match,
    output ctrl_t             ctrl,
    output logic [15:0]       pre,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag,
    output logic              ien
);
    logic sel_ctrl, sel_pre, sel_stat, sel_ien, sel_cmp, sel_cnt;

    // Address decode.
    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_pre  = (bus_addr == ADDR_W'(OFF_PRE));
    assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign sel_ien  = (bus_addr == ADDR_W'(OFF_IEN));
    assign sel_cmp  = (bus_addr == ADDR_W'(OFF_CMP));
    assign sel_cnt  = (bus_addr == ADDR_W'(OFF_CNT));

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            pre  <= '0;
            ien  <= 1'b0;
            cmp  <= '0;
        end else if (bus_we) begin
            if (sel_ctrl) begin
                ctrl.run       <= bus_wdata[BIT_RUN];
                ctrl.wait_flag <= bus_wdata[BIT_WAIT];
                ctrl.src       <= bus_wdata[SRC_LSB +: SRC_W];
                ctrl.free_run  <= bus_wdata[BIT_FREE];
                ctrl.osc_gate  <= bus_wdata[BIT_OSC];
            end
            if (sel_pre) pre <= bus_wdata[15:0];
            if (sel_ien) ien <= bus_wdata[0];
            if (sel_cmp) cmp <= bus_wdata[CNT_W-1:0];
        end
    end

    // Sticky flag: a match wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (match)                          flag <= 1'b1;
        else if (bus_we && sel_stat && bus_wdata[0]) flag <= 1'b0;
    end

    // Read mux; unmapped addresses read 0.
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[BIT_RUN]            = ctrl.run;
            bus_rdata[BIT_WAIT]           = ctrl.wait_flag;
            bus_rdata[SRC_LSB +: SRC_W]   = ctrl.src;
            bus_rdata[BIT_FREE]           = ctrl.free_run;
            bus_rdata[BIT_OSC]            = ctrl.osc_gate;
        end
        if (sel_pre)  bus_rdata[15:0]      = pre;
        if (sel_stat) bus_rdata[0]         = flag;
        if (sel_ien)  bus_rdata[0]         = ien;
        if (sel_cmp)  bus_rdata[CNT_W-1:0] = cmp;
        if (sel_cnt)  bus_rdata[CNT_W-1:0] = cnt;
    end
endmodule

// File: rtl/cmp_timer_top.sv
// Top of the compare timer: register file, tick generator and counter.
// Assumes per_tick_i and osc_tick_i are already synchronous to clk.
module cmp_timer_top
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              per_tick_i,
    input  logic              osc_tick_i,
    output logic              irq_o
);
    ctrl_t            ctrl_q;
    logic [15:0]      pre_q;
    logic [CNT_W-1:0] cmp_q, cnt_q;
    logic             flag_q, ien_q, tick, match;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt_q),
        .match(match), .ctrl(ctrl_q), .pre(pre_q), .cmp(cmp_q),
        .flag(flag_q), .ien(ien_q)
    );

    tmr_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.run), .src(ctrl_q.src),
        .osc_gate(ctrl_q.osc_gate),
        .osc_div(pre_q[OSCDIV_LSB +: OSCDIV_W]),
        .pre_div(pre_q[PRE_W-1:0]),
        .per_tick_i(per_tick_i), .osc_tick_i(osc_tick_i), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(tick && ctrl_q.run),
        .cmp(cmp_q), .cnt(cnt_q), .match(match)
    );

    // Interrupt is the flag masked by its enable.
    assign irq_o = flag_q && ien_q;
endmodule

// File: rtl/tmr_checker.sv
// Cycle-level properties of the compare timer, bound into the top module.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag
);
    // R10: every change of the count is a single upward step.
    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

    // R3: a stopped timer holds its count.
    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R7: the flag rises only where the count equals the compare value.
    assert_flag_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && $stable(cmp)) |-> (cnt == cmp));

    // R8: the flag falls only after a write of one to the status bit.
    assert_flag_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(bus_we && bus_addr == ADDR_W'(OFF_STAT) && bus_wdata[0]));
endmodule

bind cmp_timer_top tmr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .run(ctrl_q.run), .cnt(cnt_q), .cmp(cmp_q),
    .flag(flag_q)
);

// File: tb/sim_cmp_timer_top.sv
module sim_cmp_timer_top;
    localparam int CW = 12;
    localparam logic [31:0] MASK = 32'hFFF;
    localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

    logic clk = 0, rst_n = 0, bus_we = 0, per_tick = 0, osc_tick = 0, irq;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    int errors = 0, checks = 0;
    int per_ph = 0;

    always #10 clk = ~clk;

    cmp_timer_top #(.ADDR_W(8), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_tick_i(per_tick),
        .osc_tick_i(osc_tick), .irq_o(irq)
    );

    // Peripheral enable: one pulse every third cycle.
    always @(negedge clk) begin
        per_ph   <= (per_ph == 2) ? 0 : per_ph + 1;
        per_tick <= (per_ph == 2);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write is captured at the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Steps counted over a window of n cycles.
    function automatic logic [31:0] steps(input logic [31:0] c0, input logic [31:0] c1);
        return (c1 - c0) & MASK;
    endfunction

    task automatic window(input string req, input logic [31:0] ctrl, input int n,
                          input logic [31:0] exp);
        logic [31:0] c0, c1;
        wr(A_CTRL, ctrl);
        rd(A_CNT, c0);
        waitn(n);
        rd(A_CNT, c1);
        check(req, steps(c0, c1), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        void'($urandom(7));
        waitn(3);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_PRE, v);  check("R1 pre", v, 0);
        rd(A_STAT, v); check("R1 stat", v, 0);
        rd(A_CMP, v);  check("R1 cmp", v, 0);
        rd(A_CNT, v);  check("R1 cnt", v, 0);
        check("R1 irq", irq, 0);

        // R2 field readback; R3 stopped counter with wait/free bits set
        wr(A_CTRL, 32'hFFFF_F7FE);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h7C8);
        waitn(20);
        rd(A_CNT, v); check("R3 no run no count", v, 0);
        wr(A_PRE, 32'hFFFF_FFFF);
        rd(A_PRE, v); check("R2 pre readback", v, 32'hFFFF);
        wr(A_PRE, 0);

        // R3 counter read-only
        wr(A_CNT, 32'h123);
        rd(A_CNT, v); check("R3 cnt write ignored", v, 0);

        // R4 sources, R2 wait/free bits do not change rate
        window("R4 bus clock", 32'h041, 40, 40);
        window("R2 wait+free no effect", 32'h249, 40, 40);
        window("R4 peripheral", 32'h081, 30, 10);
        window("R4 unknown code", 32'h0C1, 30, 0);

        // R6 oscillator path
        osc_tick = 1;
        wr(A_PRE, 32'h7000);
        window("R6 osc div8", 32'h541, 64, 8);
        window("R6 osc gated off", 32'h141, 64, 0);
        wr(A_PRE, 32'h7001);
        window("R6 osc div8 with pre", 32'h541, 128, 8);

        // R5 random prescaler values
        for (int i = 0; i < 16; i++) begin
            int p, m;
            p = $urandom % 7;
            m = 1 + $urandom % 10;
            wr(A_PRE, p);
            window("R5 prescale", 32'h041, m * (p + 1), m);
        end
        wr(A_PRE, 0);

        // random compare/enable readback
        for (int i = 0; i < 8; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr(A_CMP, r); rd(A_CMP, v); check("R7 cmp readback", v, r & MASK);
        end

        // R7 exact match timing, R9 irq
        wr(A_CTRL, 0);
        rd(A_CNT, c);
        wr(A_CMP, (c + 5) & MASK);
        wr(A_STAT, 1);
        wr(A_IEN, 1);
        wr(A_CTRL, 32'h041);
        waitn(4);
        rd(A_STAT, v); check("R7 no flag before match", v, 0);
        check("R9 irq low before match", irq, 0);
        waitn(1);
        rd(A_STAT, v); check("R7 flag on match", v, 1);
        check("R9 irq on match", irq, 1);

        // R9 mask keeps flag
        wr(A_IEN, 0);
        check("R9 masked irq", irq, 0);
        rd(A_STAT, v); check("R9 flag kept", v, 1);
        // R8 write 0 leaves, write 1 clears
        wr(A_STAT, 0);
        rd(A_STAT, v); check("R8 write0 keeps", v, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R8 write1 clears", v, 0);

        // R8 match coincident with clear
        wr(A_CTRL, 0);
        rd(A_CNT, c);
        wr(A_CMP, (c + 1) & MASK);
        wr(A_STAT, 1);
        wr(A_IEN, 1);
        wr(A_CTRL, 32'h041);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R8 match beats clear", v, 1);
        check("R9 irq after coincident", irq, 1);

        // R7 compare one below count fires only after wrap
        wr(A_CTRL, 0);
        rd(A_CNT, c);
        wr(A_CMP, (c - 1) & MASK);
        wr(A_STAT, 1);
        wr(A_CTRL, 32'h041);
        waitn(4094);
        rd(A_STAT, v); check("R7 no early fire", v, 0);
        waitn(1);
        rd(A_STAT, v); check("R7 fires after wrap", v, 1);
        rd(A_CNT, v); check("R10 count at compare", v, (c - 1) & MASK);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule